// File: doc/BRIEF.md
# Saturating Counting-Semaphore Cell

A single 16-bit counting semaphore shared by a set of hardware threads. Each access names a view, a thread ID and a direction. The two P/V views use the count as a semaphore. A load returns the present count and then decrements it, but never below zero. A store increments the count, but never above 0xFFFF. The synchronized P/V view parks a loading thread while the count is zero. The try view answers such a load at once with zero. The raw view reads and overwrites the count with no side effects. The tag view reaches a small set of status flags.

Parked threads are held in a bitmap with one bit per thread. A P/V store that finds the count at zero while threads are parked does not raise the count. Instead it hands the unit to the lowest-numbered parked thread. That thread receives the value 1 as its delayed load result, so its load completes as if it had read 1 and decremented it back to 0. Requests arrive on a valid/ready port. Load results and delayed results leave on a valid-only response port carrying the thread ID.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the parked-thread bitmap is all zeros, the tag flags are 0, and no response or stall is asserted.
- R2: A load in view 0 (P/V synchronized) or view 1 (P/V try) with a non-zero count responds one cycle later with the count and the requesting thread ID, and leaves the count one lower.
- R3: A view 1 load with a zero count responds one cycle later with data 0, and leaves the count and the bitmap unchanged.
- R4: A view 0 load with a zero count gives no response. One cycle later it sets the requesting thread's bit in the bitmap and pulses `stall` for one cycle.
- R5: A store in view 0 or 1 raises the count by one and holds it at 0xFFFF once it reaches 0xFFFF. Stores produce no response of their own.
- R6: A view 0 or 1 store that finds the count at 0 while the bitmap is non-zero releases the lowest-numbered parked thread. One cycle later there is a response with that thread's ID and data 1, its bit is cleared, and the count stays 0.
- R7: A view 2 (raw) load returns the count one cycle later without changing it. A view 2 store replaces the count and releases no parked thread.
- R8: A view 3 (tag) load returns bit 0 = empty flag, bit 1 = full flag, bit 2 = cell-is-FIFO (always 0), and zeros above. A view 3 store writes bits 0 and 1 and ignores bit 2. Accesses in views 0 to 2 leave the flags unchanged.
- R9: `req_ready` is high at all times out of reset, so every valid request is taken in the cycle it is presented. The response port has no back-pressure, and each taken request yields at most one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high out of reset) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_view | input | 2 | 0 P/V sync, 1 P/V try, 2 raw, 3 tag |
| req_tid | input | TW | Requesting thread ID |
| req_wdata | input | W | Store data (raw and tag views) |
| rsp_valid | output | 1 | Load result present |
| rsp_tid | output | TW | Thread the result belongs to |
| rsp_data | output | W | Result value |
| stall | output | 1 | One-cycle pulse when a load is parked |
| blocked_map | output | NTHR | Parked-thread bitmap, bit i = thread i |

## Verification
Every result is registered once. A load's response appears in the cycle after the request is taken. A release appears in the cycle after the releasing store. The bitmap and `stall` change on that same edge. The driver applies each request on a falling edge and holds it through one rising edge. The monitor compares responses on the next falling edge against a queue of expected results that the driver filled. Bitmap, stall and count checks are made on that same falling edge. A parked load leaves no queue entry, so any response it produced would be reported as unexpected.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    VIEW_PV_SYNC = 2'd0,
    VIEW_PV_TRY  = 2'd1,
    VIEW_RAW     = 2'd2,
    VIEW_TAG     = 2'd3
  } view_e;

  localparam int FLAG_EMPTY_BIT = 0;
  localparam int FLAG_FULL_BIT  = 1;
  localparam int FLAG_FIFO_BIT  = 2;
endpackage

// File: rtl/sem_arith.sv
module sem_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] count,
  output logic [W-1:0] inc_sat,
  output logic [W-1:0] dec_floor,
  output logic         is_zero
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    is_zero   = (count == '0);
    inc_sat   = (count == MAXV) ? MAXV : count + ONE;
    dec_floor = is_zero ? '0 : count - ONE;
  end
endmodule

// File: rtl/sem_pick.sv
module sem_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  map,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (map[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
    if (found) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int NTHR = 8,
  parameter int W    = 16,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [1:0]      req_view,
  input  logic [TW-1:0]   req_tid,
  input  logic [W-1:0]    req_wdata,
  output logic            rsp_valid,
  output logic [TW-1:0]   rsp_tid,
  output logic [W-1:0]    rsp_data,
  output logic            stall,
  output logic [NTHR-1:0] blocked_map
);
  import sem_pkg::*;

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0]    count_q;
  logic [1:0]      flags_q;
  logic [W-1:0]    cnt_inc, cnt_dec;
  logic            cnt_zero;
  logic            pick_found;
  logic [TW-1:0]   pick_idx;
  logic [NTHR-1:0] pick_grant;
  logic [NTHR-1:0] tid_bit;
  logic [W-1:0]    tag_word;
  view_e           view;
  logic            is_pv;

  sem_arith #(.W(W)) u_arith (
    .count(count_q), .inc_sat(cnt_inc), .dec_floor(cnt_dec), .is_zero(cnt_zero)
  );

  sem_pick #(.N(NTHR), .IW(TW)) u_pick (
    .map(blocked_map), .found(pick_found), .idx(pick_idx), .grant(pick_grant)
  );

  always_comb begin
    view    = view_e'(req_view);
    is_pv   = (view == VIEW_PV_SYNC) || (view == VIEW_PV_TRY);
    tid_bit = '0;
    tid_bit[req_tid] = 1'b1;
    tag_word = '0;
    tag_word[FLAG_EMPTY_BIT] = flags_q[0];
    tag_word[FLAG_FULL_BIT]  = flags_q[1];
    tag_word[FLAG_FIFO_BIT]  = 1'b0;
  end

  assign req_ready = rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q     <= '0;
      flags_q     <= '0;
      blocked_map <= '0;
      rsp_valid   <= 1'b0;
      rsp_tid     <= '0;
      rsp_data    <= '0;
      stall       <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      stall     <= 1'b0;
      if (req_valid) begin
        if (!req_write) begin
          rsp_tid <= req_tid;
          unique case (view)
            VIEW_PV_SYNC, VIEW_PV_TRY: begin
              if (!cnt_zero) begin
                rsp_valid <= 1'b1;
                rsp_data  <= count_q;
                count_q   <= cnt_dec;
              end else if (view == VIEW_PV_TRY) begin
                rsp_valid <= 1'b1;
                rsp_data  <= '0;
              end else begin
                blocked_map <= blocked_map | tid_bit;
                stall       <= 1'b1;
              end
            end
            VIEW_RAW: begin
              rsp_valid <= 1'b1;
              rsp_data  <= count_q;
            end
            default: begin
              rsp_valid <= 1'b1;
              rsp_data  <= tag_word;
            end
          endcase
        end else begin
          unique case (view)
            VIEW_PV_SYNC, VIEW_PV_TRY: begin
              if (cnt_zero && pick_found) begin
                rsp_valid   <= 1'b1;
                rsp_tid     <= pick_idx;
                rsp_data    <= ONE;
                blocked_map <= blocked_map & ~pick_grant;
              end else begin
                count_q <= cnt_inc;
              end
            end
            VIEW_RAW: count_q <= req_wdata;
            default:  flags_q <= {req_wdata[FLAG_FULL_BIT], req_wdata[FLAG_EMPTY_BIT]};
          endcase
        end
      end
    end
  end

  assert_pv_load_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && is_pv && count_q != '0)
      |=> (rsp_valid && count_q == $past(count_q) - ONE && rsp_data == $past(count_q)));

  assert_try_no_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && view == VIEW_PV_TRY)
      |=> (rsp_valid && !stall && blocked_map == $past(blocked_map)));

  assert_park_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!rsp_valid && blocked_map != '0));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && is_pv && count_q == MAXV) |=> (count_q == MAXV));

  assert_release_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && is_pv && count_q == '0 && blocked_map != '0)
      |=> (rsp_valid && count_q == '0 &&
           $countones(blocked_map) == $countones($past(blocked_map)) - 1));

  assert_raw_no_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && view == VIEW_RAW) |=> (blocked_map == $past(blocked_map)));

  assert_flags_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && view != VIEW_TAG) |=> $stable(flags_q));
endmodule

// File: tb/sem_cell_test.sv
module sem_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 8;
  localparam int W    = 16;
  localparam int TW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [1:0]      req_view = 2'd0;
  logic [TW-1:0]   req_tid = '0;
  logic [W-1:0]    req_wdata = '0;
  logic            rsp_valid;
  logic [TW-1:0]   rsp_tid;
  logic [W-1:0]    rsp_data;
  logic            stall;
  logic [NTHR-1:0] blocked_map;

  int n_checks = 0;
  int n_fail   = 0;
  logic [TW+W-1:0] exp_q[$];
  string           tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_cell #(.NTHR(NTHR), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_view(req_view), .req_tid(req_tid),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_tid(rsp_tid),
    .rsp_data(rsp_data), .stall(stall), .blocked_map(blocked_map)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Drive one request starting at a falling edge; returns at the next falling edge.
  task automatic issue(input logic wr, input logic [1:0] v, input int tid,
                       input logic [W-1:0] d, input bit expect_rsp,
                       input int exp_tid, input logic [W-1:0] exp_data, input string req);
    req_valid = 1'b1;
    req_write = wr;
    req_view  = v;
    req_tid   = TW'(tid);
    req_wdata = d;
    if (expect_rsp) begin
      exp_q.push_back({TW'(exp_tid), exp_data});
      tag_q.push_back(req);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compare each response against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("unexpected response", {13'd0, rsp_tid, rsp_data}, 32'hFFFF_FFFF);
      end else begin
        logic [TW+W-1:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        chk(r, {13'd0, rsp_tid, rsp_data}, {13'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 blocked_map", blocked_map, 0);
    chk("R1 stall", stall, 0);
    chk("R9 req_ready", req_ready, 1);
    issue(0, 2, 0, 0, 1, 0, 16'h0000, "R1 count read");
    issue(0, 3, 0, 0, 1, 0, 16'h0000, "R1 flags read");
    // R3 try at zero
    issue(0, 1, 4, 0, 1, 4, 16'h0000, "R3 try load at zero");
    chk("R3 no park", blocked_map, 0);
    issue(0, 2, 0, 0, 1, 0, 16'h0000, "R3 count kept");
    // R5 stores, R2 loads
    for (int i = 0; i < 3; i++) issue(1, 0, 0, 0, 0, 0, 0, "R5");
    issue(0, 2, 0, 0, 1, 0, 16'd3, "R5 count after stores");
    issue(0, 0, 1, 0, 1, 1, 16'd3, "R2 sync load");
    issue(0, 1, 7, 0, 1, 7, 16'd2, "R2 try load");
    issue(0, 2, 0, 0, 1, 0, 16'd1, "R7 raw read");
    issue(0, 2, 0, 0, 1, 0, 16'd1, "R7 raw read no change");
    issue(0, 0, 2, 0, 1, 2, 16'd1, "R2 last unit");
    // R4 parking
    issue(0, 0, 5, 0, 0, 0, 0, "R4");
    chk("R4 stall pulse", stall, 1);
    chk("R4 map tid5", blocked_map, 8'h20);
    issue(0, 0, 3, 0, 0, 0, 0, "R4");
    chk("R4 map tid3", blocked_map, 8'h28);
    chk("R4 stall second", stall, 1);
    @(negedge clk);
    chk("R4 stall one cycle", stall, 0);
    // R6 release lowest first
    issue(1, 1, 0, 0, 1, 3, 16'd1, "R6 release tid3");
    chk("R6 map after first", blocked_map, 8'h20);
    issue(0, 2, 0, 0, 1, 0, 16'd0, "R6 count stays zero");
    issue(1, 0, 6, 0, 1, 5, 16'd1, "R6 release tid5");
    chk("R6 map empty", blocked_map, 8'h00);
    issue(1, 0, 6, 0, 0, 0, 0, "R5");
    issue(0, 2, 0, 0, 1, 0, 16'd1, "R5 increment after release");
    // R5 saturation
    issue(1, 2, 0, 16'hFFFE, 0, 0, 0, "R7");
    issue(1, 0, 0, 0, 0, 0, 0, "R5");
    issue(1, 1, 0, 0, 0, 0, 0, "R5");
    issue(0, 2, 0, 0, 1, 0, 16'hFFFF, "R5 saturate");
    // R8 tag view
    issue(1, 3, 0, 16'h0007, 0, 0, 0, "R8");
    issue(0, 3, 0, 0, 1, 0, 16'h0003, "R8 flags written fifo bit zero");
    issue(0, 0, 1, 0, 1, 1, 16'hFFFF, "R8 pv load");
    issue(1, 0, 1, 0, 0, 0, 0, "R8");
    issue(0, 3, 0, 0, 1, 0, 16'h0003, "R8 flags kept by pv");
    issue(1, 3, 0, 16'h0002, 0, 0, 0, "R8");
    issue(0, 3, 0, 0, 1, 0, 16'h0002, "R8 flags rewrite");
    // R7 raw write does not release
    issue(1, 2, 0, 16'd0, 0, 0, 0, "R7");
    issue(0, 0, 6, 0, 0, 0, 0, "R4");
    chk("R7 parked tid6", blocked_map, 8'h40);
    issue(1, 2, 0, 16'd5, 0, 0, 0, "R7");
    chk("R7 raw write no release", blocked_map, 8'h40);
    chk("R7 raw write no response", rsp_valid, 0);
    issue(0, 2, 0, 0, 1, 0, 16'd5, "R7 raw write value");
    repeat (2) @(negedge clk);
    chk("R9 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule